// File: doc/BRIEF.md
# Byte Mask Extract Insert Unit

A combinational 64-bit datapath unit for working on data that is not aligned to a 64-bit boundary. It can clear a byte field inside a word, extract a field from a word, or place a field at a byte position. Each of these comes in a low form and a high form. Fields are 1, 2, 4 or 8 bytes wide. The unit also zeroes whole bytes under the control of an 8-bit byte-select mask.

The caller presents operand A (the data), operand B (a register value or a literal) and a 7-bit function code. The 64-bit result and an illegal-function flag are valid in the same cycle. For every shifting function the byte offset is taken from the low three bits of B. The high forms deal with the part of a field that spills beyond bit 63. They treat an offset of zero as a special case.

Top module: `lane_manip`

## Requirements
- R1: The byte offset is `opnd_b[2:0]` and the bit shift is 8 × offset. For the mask, extract and insert functions, `opnd_b[63:3]` has no effect on the result.
- R2: Mask-low (codes 0x02, 0x12, 0x22, 0x32 for 1, 2, 4, 8 bytes) returns A with the field bytes from the offset upward cleared. Field bytes that would land above byte 7 are dropped.
- R3: Mask-high (codes 0x52, 0x62, 0x72 for 2, 4, 8 bytes) returns A unchanged when the offset is 0. Otherwise it clears A under the field mask shifted right by 64 − 8 × offset.
- R4: Extract-low (codes 0x06, 0x16, 0x26, 0x36 for 1, 2, 4, 8 bytes) shifts A right logically by 8 × offset and keeps the low field-width bits.
- R5: Extract-high (codes 0x5A, 0x6A, 0x7A for 2, 4, 8 bytes) shifts A left by (64 − 8 × offset) mod 64, so offset 0 means no shift, and keeps the low field-width bits.
- R6: Insert-low (codes 0x0B, 0x1B, 0x2B, 0x3B for 1, 2, 4, 8 bytes) shifts the low field-width bits of A left by 8 × offset, truncated to 64 bits.
- R7: Insert-high (codes 0x57, 0x67, 0x77 for 2, 4, 8 bytes) returns 0 when the offset is 0. Otherwise it returns the low field-width bits of A shifted right by 64 − 8 × offset.
- R8: Zero-select (code 0x30) clears byte i of A when `opnd_b[i]` is 1 and passes it otherwise.
- R9: Keep-select (code 0x31) passes byte i of A when `opnd_b[i]` is 1 and clears it otherwise.
- R10: Any code not listed in R2 to R9 gives a result of 0 with `bad_func` at 1. Every listed code drives `bad_func` to 0.
- R11: The unit holds no state. The result depends only on the present inputs and is valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 64 | Data operand |
| opnd_b | input | 64 | Offset / byte-select operand |
| func_code | input | 7 | Function code |
| result | output | 64 | Computed result |
| bad_func | output | 1 | Function code is not defined |

## Verification
The bench builds the unit with its default 64-bit data width, so there are eight byte lanes and a 3-bit offset. At that size every shifting function can be run at all eight offsets, and both byte-select functions over all 256 masks, in a few thousand cycles. The whole 128-code function space is also swept to cover the illegal-code flag. Operand B's upper bits are randomised on every shifting case to show that they have no effect.

// File: rtl/lane_manip.sv
`timescale 1ns/1ps
module lane_manip #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [6:0]        func_code,
  output logic [DATA_W-1:0] result,
  output logic              bad_func
);
  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);
  localparam int SH_W  = $clog2(DATA_W) + 1;

  typedef enum logic [2:0] {
    K_NONE, K_MSKL, K_MSKH, K_EXTL, K_EXTH, K_INSL, K_INSH, K_ZAP
  } kind_t;

  kind_t            kind;
  logic [1:0]       wsel;
  logic [OFS_W-1:0] ofs;
  logic [SH_W-1:0]  sh_lo, sh_hi, sh_wrap;
  logic [DATA_W-1:0] fmask, keep_mask, field;
  wire unused_b_hi = ^opnd_b[DATA_W-1:LANES];

  assign ofs     = opnd_b[OFS_W-1:0];
  assign sh_lo   = SH_W'({ofs, 3'b000});
  assign sh_hi   = SH_W'(DATA_W) - sh_lo;
  assign sh_wrap = {1'b0, sh_hi[SH_W-2:0]};
  assign field   = opnd_a & fmask;

  always_comb begin
    kind = K_NONE;
    wsel = 2'd0;
    unique case (func_code)
      7'h02: begin kind = K_MSKL; wsel = 2'd0; end
      7'h12: begin kind = K_MSKL; wsel = 2'd1; end
      7'h22: begin kind = K_MSKL; wsel = 2'd2; end
      7'h32: begin kind = K_MSKL; wsel = 2'd3; end
      7'h52: begin kind = K_MSKH; wsel = 2'd1; end
      7'h62: begin kind = K_MSKH; wsel = 2'd2; end
      7'h72: begin kind = K_MSKH; wsel = 2'd3; end
      7'h06: begin kind = K_EXTL; wsel = 2'd0; end
      7'h16: begin kind = K_EXTL; wsel = 2'd1; end
      7'h26: begin kind = K_EXTL; wsel = 2'd2; end
      7'h36: begin kind = K_EXTL; wsel = 2'd3; end
      7'h5A: begin kind = K_EXTH; wsel = 2'd1; end
      7'h6A: begin kind = K_EXTH; wsel = 2'd2; end
      7'h7A: begin kind = K_EXTH; wsel = 2'd3; end
      7'h0B: begin kind = K_INSL; wsel = 2'd0; end
      7'h1B: begin kind = K_INSL; wsel = 2'd1; end
      7'h2B: begin kind = K_INSL; wsel = 2'd2; end
      7'h3B: begin kind = K_INSL; wsel = 2'd3; end
      7'h57: begin kind = K_INSH; wsel = 2'd1; end
      7'h67: begin kind = K_INSH; wsel = 2'd2; end
      7'h77: begin kind = K_INSH; wsel = 2'd3; end
      7'h30, 7'h31: kind = K_ZAP;
      default: kind = K_NONE;
    endcase
  end

  always_comb begin
    unique case (wsel)
      2'd0:    fmask = DATA_W'(8'hFF);
      2'd1:    fmask = DATA_W'(16'hFFFF);
      2'd2:    fmask = DATA_W'(32'hFFFF_FFFF);
      default: fmask = '1;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign keep_mask[g*8 +: 8] = {8{~(opnd_b[g] ^ func_code[0])}};
  end

  always_comb begin
    result   = '0;
    bad_func = 1'b0;
    unique case (kind)
      K_MSKL: result = opnd_a & ~(fmask << sh_lo);
      K_MSKH: result = (ofs == '0) ? opnd_a : (opnd_a & ~(fmask >> sh_hi));
      K_EXTL: result = (opnd_a >> sh_lo) & fmask;
      K_EXTH: result = (opnd_a << sh_wrap) & fmask;
      K_INSL: result = field << sh_lo;
      K_INSH: result = (ofs == '0) ? '0 : (field >> sh_hi);
      K_ZAP:  result = opnd_a & keep_mask;
      default: bad_func = 1'b1;
    endcase

    AST_ILLEGAL_ZERO: assert (!bad_func || result == '0) else $error("illegal code gave data"); // R10
    AST_MASK_SUBSET: assert (!(kind inside {K_MSKL, K_MSKH, K_ZAP}) || (result & ~opnd_a) == '0) else $error("mask set a bit"); // R2
    AST_MSKH_PASS: assert (!(kind == K_MSKH && ofs == '0) || result == opnd_a) else $error("mask-high offset 0 changed A"); // R3
    AST_EXT_WIDTH: assert (!(kind inside {K_EXTL, K_EXTH}) || (result & ~fmask) == '0) else $error("extract exceeded width"); // R4
    AST_INSL_ALIGN: assert (!(kind == K_INSL) || (result & ~({DATA_W{1'b1}} << sh_lo)) == '0) else $error("insert-low below offset"); // R6
    AST_INSH_ZERO: assert (!(kind == K_INSH && ofs == '0) || result == '0) else $error("insert-high offset 0 nonzero"); // R7
  end
endmodule

// File: tb/test_lane_manip.sv
`timescale 1ns/1ps
module test_lane_manip;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] a, b, res;
  logic [6:0]  f;
  logic        ill;
  logic        armed = 1'b0;
  logic        ended = 1'b0;
  int total = 0, bad = 0;

  lane_manip #(.DATA_W(64)) i_lane_manip (
    .opnd_a(a), .opnd_b(b), .func_code(f), .result(res), .bad_func(ill)
  );

  function automatic void model(input logic [63:0] xa, input logic [63:0] xb, input logic [6:0] xf,
                                output logic [63:0] r, output logic xill, output string req);
    int kind, n, o, s;
    kind = 0; n = 0; r = '0; xill = 1'b0; req = "R10";
    case (xf)
      7'h02: begin kind = 1; n = 1; end
      7'h12: begin kind = 1; n = 2; end
      7'h22: begin kind = 1; n = 4; end
      7'h32: begin kind = 1; n = 8; end
      7'h52: begin kind = 2; n = 2; end
      7'h62: begin kind = 2; n = 4; end
      7'h72: begin kind = 2; n = 8; end
      7'h06: begin kind = 3; n = 1; end
      7'h16: begin kind = 3; n = 2; end
      7'h26: begin kind = 3; n = 4; end
      7'h36: begin kind = 3; n = 8; end
      7'h5A: begin kind = 4; n = 2; end
      7'h6A: begin kind = 4; n = 4; end
      7'h7A: begin kind = 4; n = 8; end
      7'h0B: begin kind = 5; n = 1; end
      7'h1B: begin kind = 5; n = 2; end
      7'h2B: begin kind = 5; n = 4; end
      7'h3B: begin kind = 5; n = 8; end
      7'h57: begin kind = 6; n = 2; end
      7'h67: begin kind = 6; n = 4; end
      7'h77: begin kind = 6; n = 8; end
      7'h30: kind = 7;
      7'h31: kind = 8;
      default: kind = 0;
    endcase
    o = int'(xb[2:0]);
    s = (8 - o) % 8;
    case (kind)
      1: begin req = "R2 (R1 offset)"; r = xa;
         for (int i = 0; i < 8; i++) if (i >= o && i < o + n) r[i*8 +: 8] = 8'h00; end
      2: begin req = "R3 (R1 offset)"; r = xa;
         if (o != 0) for (int i = 0; i < 8; i++) if (i < o + n - 8) r[i*8 +: 8] = 8'h00; end
      3: begin req = "R4 (R1 offset)";
         for (int j = 0; j < 8; j++) if (j < n && j + o < 8) r[j*8 +: 8] = xa[(j+o)*8 +: 8]; end
      4: begin req = "R5 (R1 offset)";
         for (int j = 0; j < 8; j++) if (j < n && j >= s) r[j*8 +: 8] = xa[(j-s)*8 +: 8]; end
      5: begin req = "R6 (R1 offset)";
         for (int i = 0; i < 8; i++) if (i - o >= 0 && i - o < n) r[i*8 +: 8] = xa[(i-o)*8 +: 8]; end
      6: begin req = "R7 (R1 offset)";
         if (o != 0) for (int i = 0; i < 8; i++) if (i + 8 - o < n) r[i*8 +: 8] = xa[(i+8-o)*8 +: 8]; end
      7: begin req = "R8";
         for (int i = 0; i < 8; i++) r[i*8 +: 8] = xb[i] ? 8'h00 : xa[i*8 +: 8]; end
      8: begin req = "R9";
         for (int i = 0; i < 8; i++) r[i*8 +: 8] = xb[i] ? xa[i*8 +: 8] : 8'h00; end
      default: xill = 1'b1;
    endcase
  endfunction

  // R11: outputs compared half a cycle after the inputs change, with no register in between
  always @(negedge clk) begin
    logic [63:0] er;
    logic        ei;
    string       rq;
    if (armed && !ended) begin
      model(a, b, f, er, ei, rq);
      total++;
      if (res !== er || ill !== ei) begin
        bad++;
        $display("FAIL %s R11: f=%h b=%h got %h/%b exp %h/%b", rq, f, b, res, ill, er, ei);
      end
    end
  end

  task automatic apply(input logic [63:0] xa, input logic [63:0] xb, input logic [6:0] xf);
    @(posedge clk);
    a = xa; b = xb; f = xf;
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  logic [6:0] codes [21] = '{7'h02, 7'h12, 7'h22, 7'h32, 7'h52, 7'h62, 7'h72,
                             7'h06, 7'h16, 7'h26, 7'h36, 7'h5A, 7'h6A, 7'h7A,
                             7'h0B, 7'h1B, 7'h2B, 7'h3B, 7'h57, 7'h67, 7'h77};

  initial begin
    logic [63:0] pat [3];
    a = '0; b = '0; f = 7'h02;
    pat[0] = 64'h8877_6655_4433_2211;
    pat[1] = {$urandom(7), $urandom};
    pat[2] = ~pat[0];
    repeat (3) @(posedge clk);
    armed = 1'b1;           // idle state: zero operands on a legal code
    @(posedge clk);
    foreach (codes[c])
      for (int o = 0; o < 8; o++)
        for (int p = 0; p < 3; p++)
          apply(pat[p], {$urandom, $urandom(), 5'($urandom), 3'(o)}, codes[c]);
    for (int k = 0; k < 2; k++)
      for (int m = 0; m < 256; m++)
        apply({$urandom, $urandom}, {$urandom, 24'($urandom), 8'(m)}, 7'(7'h30 + k));
    for (int c = 0; c < 128; c++)
      apply({$urandom, $urandom}, {$urandom, $urandom}, 7'(c));
    @(posedge clk);
    @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      bad++;
      total++;
      $display("FAIL watchdog R11: got timeout exp completion");
      finish_up();
    end
  end
endmodule